// File: doc/BRIEF.md
# Byte-Wide Host Port with Shared Word RAM

This block is a slave port through which an external host processor reads and writes a local RAM of 16-bit words over an 8-bit data path. A word moves as two byte accesses. A byte-half input marks each access as the high or the low byte. A two-bit select input chooses one of three host-visible registers: a control word, a RAM address, or the data window. The data window reaches the RAM at the address held in the address register. The control word can also be read and written whole by the local processor. The address register and the data window can be reached only from the host.

The host strobe is asynchronous. It is brought into the local clock domain through a synchronizer, and each access runs from the synchronized assertion edge. A state machine has four states: IDLE, EXEC, FETCH and HOLD. Its transitions are IDLE to EXEC on a synchronized strobe edge, EXEC to FETCH for a high-byte data read, EXEC to HOLD for every other access, FETCH to HOLD, and HOLD to IDLE once the synchronized strobe is released. The RAM has a single port. The host uses it for exactly one cycle per word, and in that cycle it pre-empts the local processor. A ready output tells the host when it may sample read data or release the strobe.

The bidirectional data bus is split into an input, an output and an output enable, for a pad ring to join.

Top module: `hpi_byte_port`

## Requirements
- R1: `host_strb_n` passes through a SYNC_STAGES-flop synchronizer (default two). An access executes once, on the synchronized assertion edge. Holding the strobe low for longer does not repeat the access.
- R2: `host_sel` encodes 0 = control, 1 = data, 2 = address, 3 = unused. For the unused code, writes change nothing and reads return 0x00. `host_hi` = 1 addresses bits 15:8 and `host_hi` = 0 addresses bits 7:0.
- R3: The host can write and read back both bytes of the 16-bit address register. The RAM word index is the low AW bits of that register, so higher address bits wrap.
- R4: A high-byte data write only stages the byte. A low-byte data write stores {staged byte, low byte} to the RAM at the current address, in one RAM cycle.
- R5: A high-byte data read fetches the whole word and returns bits 15:8. A following low-byte data read returns bits 7:0 of that latched copy, even if the RAM word has changed since the fetch.
- R6: The host writes the control word one byte at a time, and the local processor writes it whole through `loc_ctl_we`. `ctl_q` shows its value. If both write in the same cycle, the host byte is applied and the local write is dropped.
- R7: During a cycle in which the host uses the RAM, a pending local request gets no grant. This costs the local side exactly one cycle per host RAM access. At all other times a local request is granted in the same cycle. Local read data appears with `loc_rvalid` one cycle after a read grant.
- R8: `host_rdy` is low from the cycle the access executes until its RAM cycle has finished (EXEC and FETCH). It is high in IDLE and HOLD, and read data on `host_dout` is valid once it returns high.
- R9: Reset clears the control word, the address register, the staging byte and the latched word, and sets `host_rdy` to 1. A strobe that is held low during reset and still held after reset is refused. Only a fresh assertion starts an access.
- R10: `host_doe` is 1 only while the strobe is low, `host_rnw` = 1, and reset is not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Local asynchronous reset, active low |
| host_strb_n | input | 1 | Host access strobe, active low, asynchronous |
| host_rnw | input | 1 | 1 = host read, 0 = host write |
| host_sel | input | 2 | Register select (0 control, 1 data, 2 address, 3 unused) |
| host_hi | input | 1 | Byte half: 1 high, 0 low |
| host_din | input | 8 | Byte from host |
| host_dout | output | 8 | Byte to host |
| host_doe | output | 1 | Drive enable for the host data bus |
| host_rdy | output | 1 | Host may proceed when high |
| loc_req | input | 1 | Local RAM request |
| loc_we | input | 1 | Local write enable |
| loc_addr | input | AW | Local word address |
| loc_wdata | input | 16 | Local write data |
| loc_gnt | output | 1 | Local request served this cycle |
| loc_rdata | output | 16 | Local read data |
| loc_rvalid | output | 1 | loc_rdata valid |
| loc_ctl_we | input | 1 | Local control-word write |
| loc_ctl_wdata | input | 16 | Local control-word value |
| ctl_q | output | 16 | Current control word |

## Verification
The bench holds a local read request open while the host performs data accesses, and counts the cycles in which no grant is given. A wrong arbiter would show zero stalls, which corrupts the RAM, or more than one stall, which starves the local side. The strobe is also held for many cycles, so a plain level detector would write the word over and over. A high-byte-only write is followed by a read of the RAM, to catch a design that writes the RAM at the first byte. A local write between the two read halves catches a design that fetches the low byte again instead of taking it from the latched copy. A strobe held across reset would start a spurious control write in a design whose synchronizer resets to idle.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXEC  = 2'd1,
        ST_FETCH = 2'd2,
        ST_HOLD  = 2'd3
    } hpi_state_e;

    typedef enum logic [1:0] {
        RS_CTL  = 2'd0,
        RS_DATA = 2'd1,
        RS_ADDR = 2'd2,
        RS_NONE = 2'd3
    } hpi_rsel_e;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/hpi_strobe_sync.sv
module hpi_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_n,
    output logic active,
    output logic rise
);
    // Chain holds the active-high strobe level; resets to "active" so a
    // strobe already held through reset never yields an edge.
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= ~strb_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign active = chain[STAGES-1];
    assign rise   = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/hpi_arbiter.sv
module hpi_arbiter #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          host_en,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          loc_req,
    input  logic          loc_we,
    input  logic [AW-1:0] loc_addr,
    input  logic [DW-1:0] loc_wdata,
    output logic          loc_gnt,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata
);
    // Host has fixed priority on the single RAM port.
    always_comb begin
        loc_gnt = loc_req & ~host_en;
        if (host_en) begin
            ram_en    = 1'b1;
            ram_we    = host_we;
            ram_addr  = host_addr;
            ram_wdata = host_wdata;
        end else begin
            ram_en    = loc_req;
            ram_we    = loc_req & loc_we;
            ram_addr  = loc_addr;
            ram_wdata = loc_wdata;
        end
    end
endmodule

// File: rtl/hpi_ram.sv
module hpi_ram #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/hpi_byte_port.sv
module hpi_byte_port
    import hpi_pkg::*;
#(
    parameter int AW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_strb_n,
    input  logic          host_rnw,
    input  logic [1:0]    host_sel,
    input  logic          host_hi,
    input  logic [7:0]    host_din,
    output logic [7:0]    host_dout,
    output logic          host_doe,
    output logic          host_rdy,
    input  logic          loc_req,
    input  logic          loc_we,
    input  logic [AW-1:0] loc_addr,
    input  logic [15:0]   loc_wdata,
    output logic          loc_gnt,
    output logic [15:0]   loc_rdata,
    output logic          loc_rvalid,
    input  logic          loc_ctl_we,
    input  logic [15:0]   loc_ctl_wdata,
    output logic [15:0]   ctl_q
);
    localparam int BW = BYTE_W;
    localparam int WW = WORD_W;

    hpi_state_e state, state_nxt;
    hpi_rsel_e  sel;

    logic          strb_act, strb_rise;
    logic [WW-1:0] addr_q;
    logic [BW-1:0] stage_q;
    logic [WW-1:0] latch_q;
    logic [BW-1:0] dout_q;
    logic          host_ram_en;
    logic          host_ctl_wr;
    logic          ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [WW-1:0] ram_wdata, ram_rdata;

    assign sel = hpi_rsel_e'(host_sel);

    hpi_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb_n (host_strb_n),
        .active (strb_act),
        .rise   (strb_rise)
    );

    // Host touches the RAM on the low-byte write and the high-byte read.
    assign host_ram_en = (state == ST_EXEC) && (sel == RS_DATA)
                         && (host_rnw ? host_hi : !host_hi);
    assign host_ctl_wr = (state == ST_EXEC) && (sel == RS_CTL) && !host_rnw;

    hpi_arbiter #(.AW(AW), .DW(WW)) u_arb (
        .host_en    (host_ram_en),
        .host_we    (!host_rnw),
        .host_addr  (addr_q[AW-1:0]),
        .host_wdata ({stage_q, host_din}),
        .loc_req    (loc_req),
        .loc_we     (loc_we),
        .loc_addr   (loc_addr),
        .loc_wdata  (loc_wdata),
        .loc_gnt    (loc_gnt),
        .ram_en     (ram_en),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata)
    );

    hpi_ram #(.AW(AW), .DW(WW)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (strb_rise) state_nxt = ST_EXEC;
            ST_EXEC:  state_nxt = (host_ram_en && host_rnw) ? ST_FETCH : ST_HOLD;
            ST_FETCH: state_nxt = ST_HOLD;
            ST_HOLD:  if (!strb_act) state_nxt = ST_IDLE;
        endcase
    end

    // Register file and output data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            addr_q     <= '0;
            stage_q    <= '0;
            latch_q    <= '0;
            dout_q     <= '0;
            loc_rvalid <= 1'b0;
        end else begin
            loc_rvalid <= loc_gnt & ~loc_we;
            if (!host_ctl_wr && loc_ctl_we) ctl_q <= loc_ctl_wdata;
            unique case (state)
                ST_EXEC: begin
                    unique case (sel)
                        RS_CTL: begin
                            if (!host_rnw) begin
                                if (host_hi) ctl_q[15:8] <= host_din;
                                else         ctl_q[7:0]  <= host_din;
                            end else begin
                                dout_q <= host_hi ? ctl_q[15:8] : ctl_q[7:0];
                            end
                        end
                        RS_ADDR: begin
                            if (!host_rnw) begin
                                if (host_hi) addr_q[15:8] <= host_din;
                                else         addr_q[7:0]  <= host_din;
                            end else begin
                                dout_q <= host_hi ? addr_q[15:8] : addr_q[7:0];
                            end
                        end
                        RS_DATA: begin
                            if (!host_rnw && host_hi) stage_q <= host_din;
                            if (host_rnw && !host_hi) dout_q  <= latch_q[7:0];
                        end
                        RS_NONE: begin
                            if (host_rnw) dout_q <= '0;
                        end
                    endcase
                end
                ST_FETCH: begin
                    latch_q <= ram_rdata;
                    dout_q  <= ram_rdata[15:8];
                end
                default: ;
            endcase
        end
    end

    assign host_dout = dout_q;
    assign host_doe  = rst_n & ~host_strb_n & host_rnw;
    assign host_rdy  = (state == ST_IDLE) || (state == ST_HOLD);
    assign loc_rdata = ram_rdata;
endmodule

// File: rtl/hpi_byte_port_chk.sv
module hpi_byte_port_chk
    import hpi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] state,
    input logic       strb_rise,
    input logic       host_ram_en,
    input logic       loc_req,
    input logic       loc_we,
    input logic       loc_gnt,
    input logic       loc_rvalid,
    input logic       host_rdy,
    input logic       host_rnw,
    input logic       host_hi,
    input logic [1:0] host_sel,
    input logic [7:0] host_din,
    input logic [15:0] ctl_q
);
    // R7: host RAM cycle blocks the local grant
    a_r7_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ram_en && loc_req) |-> !loc_gnt);

    // R7: free port grants the local request at once
    a_r7_grant_free: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_req && !host_ram_en) |-> loc_gnt);

    // R7: read data valid one cycle after a read grant
    a_r7_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_gnt && !loc_we) |=> loc_rvalid);

    // R8: busy while executing or fetching
    a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC || state == ST_FETCH) |-> !host_rdy);

    // R1: idle persists without a synchronized edge
    a_r1_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !strb_rise) |=> (state == ST_IDLE));

    // R6: host low-byte control write lands next cycle
    a_r6_ctl_host: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && host_sel == 2'd0 && !host_rnw && !host_hi)
        |=> (ctl_q[7:0] == $past(host_din)));
endmodule

bind hpi_byte_port hpi_byte_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .strb_rise   (strb_rise),
    .host_ram_en (host_ram_en),
    .loc_req     (loc_req),
    .loc_we      (loc_we),
    .loc_gnt     (loc_gnt),
    .loc_rvalid  (loc_rvalid),
    .host_rdy    (host_rdy),
    .host_rnw    (host_rnw),
    .host_hi     (host_hi),
    .host_sel    (host_sel),
    .host_din    (host_din),
    .ctl_q       (ctl_q)
);

// File: tb/hpi_byte_port_test.sv
module hpi_byte_port_test;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_strb_n = 1'b1;
    logic          host_rnw = 1'b0;
    logic [1:0]    host_sel = 2'd0;
    logic          host_hi = 1'b0;
    logic [7:0]    host_din = 8'h00;
    logic [7:0]    host_dout;
    logic          host_doe, host_rdy;
    logic          loc_req = 1'b0, loc_we = 1'b0;
    logic [AW-1:0] loc_addr = '0;
    logic [15:0]   loc_wdata = '0;
    logic          loc_gnt;
    logic [15:0]   loc_rdata;
    logic          loc_rvalid;
    logic          loc_ctl_we = 1'b0;
    logic [15:0]   loc_ctl_wdata = '0;
    logic [15:0]   ctl_q;

    int n_tests = 0, n_fail = 0, stalls = 0, cycles = 0;
    logic [15:0] m_mem [256];
    logic [15:0] m_ctl = '0, m_addr = '0;
    logic [7:0]  m_stage = '0;

    always #4 clk = ~clk;

    hpi_byte_port #(.AW(AW)) uut (.*);

    always @(negedge clk) if (loc_req && !loc_gnt) stalls++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] exp_rd(input logic [1:0] sel, input logic hi);
        case (sel)
            2'd0: return hi ? {8'h0, m_ctl[15:8]} : {8'h0, m_ctl[7:0]};
            2'd2: return hi ? {8'h0, m_addr[15:8]} : {8'h0, m_addr[7:0]};
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_op(input logic [1:0] sel, input logic hi, input logic rnw,
                           input logic [7:0] d, input int hold, output logic [7:0] q);
        int n = 0;
        @(negedge clk);
        host_sel = sel; host_hi = hi; host_rnw = rnw; host_din = d; host_strb_n = 1'b0;
        while (host_rdy && n < 30) begin @(negedge clk); n++; end
        while (!host_rdy && n < 60) begin @(negedge clk); n++; end
        repeat (hold) @(negedge clk);
        q = host_dout;
        if (rnw) chk("R10 doe on read", {15'h0, host_doe}, 16'h1);
        host_strb_n = 1'b1;
        #1;
        chk("R10 doe released", {15'h0, host_doe}, 16'h0);
        repeat (4) @(negedge clk);
        if (!rnw) begin
            case (sel)
                2'd0: if (hi) m_ctl[15:8] = d; else m_ctl[7:0] = d;
                2'd2: if (hi) m_addr[15:8] = d; else m_addr[7:0] = d;
                2'd1: if (hi) m_stage = d; else m_mem[m_addr[7:0]] = {m_stage, d};
                default: ;
            endcase
        end
    endtask

    task automatic host_wr_word(input logic [15:0] a, input logic [15:0] d);
        logic [7:0] q;
        host_op(2'd2, 1'b1, 1'b0, a[15:8], 0, q);
        host_op(2'd2, 1'b0, 1'b0, a[7:0], 0, q);
        host_op(2'd1, 1'b1, 1'b0, d[15:8], 0, q);
        host_op(2'd1, 1'b0, 1'b0, d[7:0], 0, q);
    endtask

    task automatic host_rd_word(input logic [15:0] a, output logic [15:0] w);
        logic [7:0] qh, ql;
        host_op(2'd2, 1'b1, 1'b0, a[15:8], 0, qh);
        host_op(2'd2, 1'b0, 1'b0, a[7:0], 0, qh);
        host_op(2'd1, 1'b1, 1'b1, 8'h00, 0, qh);
        host_op(2'd1, 1'b0, 1'b1, 8'h00, 0, ql);
        w = {qh, ql};
    endtask

    task automatic loc_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        loc_req = 1'b1; loc_we = 1'b1; loc_addr = a; loc_wdata = d;
        #1;
        while (!loc_gnt) begin @(negedge clk); #1; end
        @(negedge clk);
        loc_req = 1'b0; loc_we = 1'b0;
        m_mem[a] = d;
    endtask

    task automatic loc_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        loc_req = 1'b1; loc_we = 1'b0; loc_addr = a;
        #1;
        while (!loc_gnt) begin @(negedge clk); #1; end
        @(negedge clk);
        loc_req = 1'b0;
        chk("R7 rvalid after grant", {15'h0, loc_rvalid}, 16'h1);
        d = loc_rdata;
    endtask

    initial begin
        logic [7:0]  q;
        logic [15:0] w;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        chk("R9 reset rdy", {15'h0, host_rdy}, 16'h1);
        chk("R9 reset ctl", ctl_q, 16'h0);
        chk("R10 reset doe", {15'h0, host_doe}, 16'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        host_op(2'd2, 1'b1, 1'b1, 8'h00, 0, q); chk("R9 addr hi after reset", {8'h0, q}, 16'h0);

        // R6 control register via host bytes and local word
        host_op(2'd0, 1'b1, 1'b0, 8'hA5, 0, q);
        host_op(2'd0, 1'b0, 1'b0, 8'h3C, 0, q);
        chk("R6 ctl host write", ctl_q, 16'hA53C);
        host_op(2'd0, 1'b1, 1'b1, 8'h00, 0, q); chk("R6 ctl host read hi", {8'h0, q}, 16'h00A5);
        @(negedge clk); loc_ctl_we = 1'b1; loc_ctl_wdata = 16'h1111;
        @(negedge clk); loc_ctl_we = 1'b0; m_ctl = 16'h1111;
        chk("R6 ctl local write", ctl_q, 16'h1111);
        host_op(2'd0, 1'b0, 1'b1, 8'h00, 0, q); chk("R6 ctl host read lo", {8'h0, q}, 16'h0011);

        // R2 unused select
        host_op(2'd3, 1'b0, 1'b0, 8'hFF, 0, q);
        host_op(2'd3, 1'b1, 1'b1, 8'h00, 0, q); chk("R2 unused reads zero", {8'h0, q}, 16'h0);
        chk("R2 unused write no ctl effect", ctl_q, 16'h1111);
        host_op(2'd2, 1'b0, 1'b1, 8'h00, 0, q); chk("R2 unused write no addr effect", {8'h0, q}, 16'h0);

        // R3 address readback and wrap
        host_wr_word(16'h1234, 16'hBEEF);
        host_op(2'd2, 1'b1, 1'b1, 8'h00, 0, q); chk("R3 addr hi readback", {8'h0, q}, 16'h0012);
        loc_read(8'h34, w); chk("R3 wrapped index", w, 16'hBEEF);

        // R4 high byte only stages
        loc_write(8'h40, 16'hAAAA);
        host_op(2'd2, 1'b0, 1'b0, 8'h40, 0, q);
        host_op(2'd1, 1'b1, 1'b0, 8'h55, 0, q);
        loc_read(8'h40, w); chk("R4 hi byte not written", w, 16'hAAAA);
        host_op(2'd1, 1'b0, 1'b0, 8'h66, 0, q);
        loc_read(8'h40, w); chk("R4 word on lo byte", w, 16'h5566);

        // R5 latched copy for low byte
        host_op(2'd1, 1'b1, 1'b1, 8'h00, 0, q); chk("R5 hi read", {8'h0, q}, 16'h0055);
        loc_write(8'h40, 16'h7788);
        host_op(2'd1, 1'b0, 1'b1, 8'h00, 0, q); chk("R5 lo from latch", {8'h0, q}, 16'h0066);

        // R7 / R1 contention with long strobe
        @(negedge clk); loc_req = 1'b1; loc_we = 1'b0; loc_addr = 8'h00; stalls = 0;
        host_op(2'd1, 1'b0, 1'b0, 8'h99, 20, q);
        chk("R7 R1 one stall per long write", stalls[15:0], 16'd1);
        stalls = 0;
        host_op(2'd1, 1'b1, 1'b1, 8'h00, 0, q);
        chk("R7 one stall per read", stalls[15:0], 16'd1);
        stalls = 0;
        host_op(2'd0, 1'b0, 1'b0, 8'h42, 0, q);
        chk("R7 no stall for ctl", stalls[15:0], 16'd0);
        @(negedge clk); loc_req = 1'b0;
        loc_read(8'h40, w); chk("R4 contention write", w, 16'h5599);

        // Random mix
        for (int i = 0; i < 16; i++) loc_write(i[7:0], 16'($urandom));
        for (int i = 0; i < 120; i++) begin
            logic [15:0] a, d;
            a = {8'($urandom), 4'h0, 4'($urandom)};
            d = 16'($urandom);
            case ($urandom % 5)
                0: host_wr_word(a, d);
                1: begin host_rd_word(a, w); chk("R5 random host read", w, m_mem[a[7:0]]); end
                2: loc_write(a[7:0], d);
                3: begin loc_read(a[7:0], w); chk("R4 random local read", w, m_mem[a[7:0]]); end
                default: begin
                    logic [1:0] s; logic h;
                    s = ($urandom % 2) ? 2'd0 : 2'd2; h = 1'($urandom);
                    host_op(s, h, 1'b1, 8'h00, 0, q);
                    chk("R2 random reg read", {8'h0, q}, exp_rd(s, h));
                end
            endcase
        end

        // R9 strobe held across reset is refused
        @(negedge clk);
        host_sel = 2'd0; host_hi = 1'b0; host_rnw = 1'b0; host_din = 8'h5A; host_strb_n = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; m_ctl = '0; m_addr = '0; m_stage = '0;
        begin
            int busy = 0;
            repeat (10) begin @(negedge clk); if (!host_rdy) busy++; end
            chk("R9 no access after reset", {15'h0, busy != 0}, 16'h0);
        end
        chk("R9 ctl untouched", ctl_q, 16'h0);
        host_strb_n = 1'b1;
        repeat (4) @(negedge clk);
        host_op(2'd0, 1'b0, 1'b0, 8'h5A, 0, q);
        chk("R9 fresh strobe accepted", ctl_q, 16'h005A);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule